// File: doc/BRIEF.md
# Random Word Generator Register Block

This block is a small memory-mapped random-number peripheral. Software sees four 32-bit registers on a single-cycle bus: a control register, a status register, a write-only entropy register and a one-word output register. Once generation is enabled and the block is awake, a free-running pseudorandom generator fills the empty output register after a fixed latency. Reading a full output register returns the word and empties it.

Reading the output while it is empty is an underflow. An underflow raises three status flags. Each flag is cleared by a different event: a read of status, a valid output read, or a clear command. The error flag drives an interrupt request unless that request is masked. Two enables cannot be cleared by software. One starts generation. The other arms a security-violation flag that records an underflow until reset. Sleep comes either from a control bit or from a doze input.

The generator is a 32-bit maximal-length LFSR that advances every clock. Every entropy write is XORed into its state.

Top module: `rand_word_regs`

## Requirements
- R1: After reset, control reads 0x00000000, status reads 0x00010000 and irq_o is 0.
- R2: Register offsets are control 0x0, status 0x4, entropy 0x8 and output 0xC. Control bits are gen-enable[0], assurance-enable[1], irq-mask[2], error-clear[3] and sleep[4]. The error-clear bit and the whole entropy register read as 0.
- R3: Gen-enable and assurance-enable are sticky. Writing 0 to them leaves them at 1 until reset.
- R4: When gen-enable is 1, the block is awake and the output is empty, the output level (status[15:8]) becomes 1 at the 16th rising edge of that condition. Sleep restarts this count.
- R5: An output read at level 1 returns the stored nonzero word. After the read, level and word are 0 and last-read-status (status[1]) is 0.
- R6: An output read at level 0 is an underflow. It returns 0 and sets error (status[3]), underflow (status[2]) and last-read-status (status[1]).
- R7: A status read clears underflow and last-read-status but leaves error unchanged.
- R8: Writing 1 to error-clear clears error. No other event clears it.
- R9: irq_o is 1 exactly when error is 1 and irq-mask is 0.
- R10: An underflow while assurance-enable is 1 sets security-violation (status[0]). Only reset clears it.
- R11: Status[4] is 1 when the control sleep bit or doze_i is 1. While it is 1, no word is loaded.
- R12: Successive output words come from the LFSR. An entropy write XORs its value into the state, and a zero result is replaced by the seed. Output words are never 0 and consecutive words differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | ADDR_W | Byte address, word aligned |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid in the cycle of the access |
| doze_i | input | 1 | External sleep request |
| irq_o | output | 1 | Unmasked error interrupt request |

## Verification
The bench builds the block with its default parameters: a 32-bit bus, a 4-bit address and a 16-clock load latency. With a 16-clock latency, the boundary one cycle before and one cycle after a load can be hit directly.

Random waits of 0 to 24 clocks between output reads spread over both sides of that boundary. This mixes valid reads, underflows and entropy writes, so the clear rules of each flag are exercised in many orders.

// File: rtl/rwg_pkg.sv
package rwg_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_ENT  = 2'd2,
    SEL_OUT  = 2'd3
  } reg_sel_e;

  // control bit positions
  localparam int unsigned C_GEN   = 0;
  localparam int unsigned C_ASSUR = 1;
  localparam int unsigned C_MASK  = 2;
  localparam int unsigned C_CLR   = 3;
  localparam int unsigned C_SLEEP = 4;

  // status bit positions
  localparam int unsigned S_SECV  = 0;
  localparam int unsigned S_LRS   = 1;
  localparam int unsigned S_UFLOW = 2;
  localparam int unsigned S_ERR   = 3;
  localparam int unsigned S_SLEEP = 4;
  localparam int unsigned S_LVL   = 8;
  localparam int unsigned S_SIZE  = 16;
  localparam int unsigned FIELD_W = 8;
  localparam int unsigned OUT_WORDS = 1;
endpackage

// File: rtl/rwg_lfsr.sv
module rwg_lfsr #(
  parameter int unsigned W    = 32,
  parameter logic [W-1:0] TAPS = 32'h8020_0003,
  parameter logic [W-1:0] SEED = 32'h1ACE_B00C
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mix_en_i,
  input  logic [W-1:0] mix_val_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q, step, mixed, state_d;

  always_comb begin
    step  = (state_q >> 1) ^ (state_q[0] ? TAPS : '0);
    mixed = state_q ^ mix_val_i;
    if (mix_en_i) state_d = (mixed == '0) ? SEED : mixed;
    else          state_d = step;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/rwg_outbuf.sv
module rwg_outbuf #(
  parameter int unsigned W   = 32,
  parameter int unsigned LAT = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] src_i,
  input  logic         take_i,
  output logic [W-1:0] word_o,
  output logic         full_o
);
  localparam int unsigned CNT_W = $clog2(LAT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LAT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     word_q;
  logic             full_q, load;

  assign load = run_i && !full_q && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      word_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (!run_i || full_q || load) cnt_q <= '0;
      else                          cnt_q <= cnt_q + 1'b1;
      if (load) begin
        word_q <= src_i;
        full_q <= 1'b1;
      end else if (take_i && full_q) begin
        word_q <= '0;
        full_q <= 1'b0;
      end
    end
  end

  assign word_o = word_q;
  assign full_o = full_q;
endmodule

// File: rtl/rwg_flags.sv
module rwg_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uflow_i,
  input  logic good_rd_i,
  input  logic stat_rd_i,
  input  logic clr_i,
  input  logic assur_i,
  output logic secv_o,
  output logic lrs_o,
  output logic uflow_o,
  output logic err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      secv_o  <= 1'b0;
      lrs_o   <= 1'b0;
      uflow_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      if (uflow_i && assur_i) secv_o <= 1'b1;

      if (uflow_i)                     lrs_o <= 1'b1;
      else if (good_rd_i || stat_rd_i) lrs_o <= 1'b0;

      if (uflow_i)        uflow_o <= 1'b1;
      else if (stat_rd_i) uflow_o <= 1'b0;

      if (uflow_i)    err_o <= 1'b1;
      else if (clr_i) err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rand_word_regs.sv
module rand_word_regs
  import rwg_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned LOAD_LAT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              doze_i,
  output logic              irq_o
);
  reg_sel_e    sel;
  logic        hit, rd, wr;
  logic        go_q, ha_q, intm_q, sleep_q, asleep;
  logic        ctrl_wr, stat_rd, ent_wr, out_rd;
  logic        uflow, good_rd, clri_pulse;
  logic        secv, lrs, oru, erri, out_full;
  logic [DATA_W-1:0] lfsr_q, out_word;

  assign sel     = reg_sel_e'(addr_i[3:2]);
  assign hit     = req_i && (addr_i[1:0] == 2'b00);
  assign rd      = hit && !we_i;
  assign wr      = hit && we_i;
  assign ctrl_wr = wr && (sel == SEL_CTRL);
  assign ent_wr  = wr && (sel == SEL_ENT);
  assign stat_rd = rd && (sel == SEL_STAT);
  assign out_rd  = rd && (sel == SEL_OUT);
  assign uflow   = out_rd && !out_full;
  assign good_rd = out_rd && out_full;
  assign clri_pulse = ctrl_wr && wdata_i[C_CLR];
  assign asleep  = sleep_q || doze_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_q    <= 1'b0;
      ha_q    <= 1'b0;
      intm_q  <= 1'b0;
      sleep_q <= 1'b0;
    end else if (ctrl_wr) begin
      go_q    <= go_q | wdata_i[C_GEN];
      ha_q    <= ha_q | wdata_i[C_ASSUR];
      intm_q  <= wdata_i[C_MASK];
      sleep_q <= wdata_i[C_SLEEP];
    end
  end

  rwg_lfsr #(.W(DATA_W)) u_lfsr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mix_en_i  (ent_wr),
    .mix_val_i (wdata_i),
    .state_o   (lfsr_q)
  );

  rwg_outbuf #(.W(DATA_W), .LAT(LOAD_LAT)) u_outbuf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (go_q && !asleep),
    .src_i  (lfsr_q),
    .take_i (out_rd),
    .word_o (out_word),
    .full_o (out_full)
  );

  rwg_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .uflow_i   (uflow),
    .good_rd_i (good_rd),
    .stat_rd_i (stat_rd),
    .clr_i     (clri_pulse),
    .assur_i   (ha_q),
    .secv_o    (secv),
    .lrs_o     (lrs),
    .uflow_o   (oru),
    .err_o     (erri)
  );

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (sel)
        SEL_CTRL: begin
          rdata_o[C_GEN]   = go_q;
          rdata_o[C_ASSUR] = ha_q;
          rdata_o[C_MASK]  = intm_q;
          rdata_o[C_SLEEP] = sleep_q;
        end
        SEL_STAT: begin
          rdata_o[S_SECV]  = secv;
          rdata_o[S_LRS]   = lrs;
          rdata_o[S_UFLOW] = oru;
          rdata_o[S_ERR]   = erri;
          rdata_o[S_SLEEP] = asleep;
          rdata_o[S_LVL +: FIELD_W]  = FIELD_W'(out_full);
          rdata_o[S_SIZE +: FIELD_W] = FIELD_W'(OUT_WORDS);
        end
        SEL_OUT:  rdata_o = out_word;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign irq_o = erri && !intm_q;
endmodule

// File: rtl/rwg_checker.sv
module rwg_checker #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              go_q,
  input logic              ha_q,
  input logic              intm_q,
  input logic              asleep,
  input logic              uflow,
  input logic              clri_pulse,
  input logic              secv,
  input logic              lrs,
  input logic              oru,
  input logic              erri,
  input logic              out_full,
  input logic              irq_o,
  input logic [DATA_W-1:0] lfsr_q
);
  a_r3_gen_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni) go_q |=> go_q);
  a_r3_assur_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni) ha_q |=> ha_q);
  a_r4_load_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_full) |-> $past(go_q && !asleep));
  a_r6_underflow_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uflow |=> (erri && oru && lrs));
  a_r8_clear_err: assert property (@(posedge clk_i) disable iff (!rst_ni) clri_pulse |=> !erri);
  a_r9_mask_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni) intm_q |-> !irq_o);
  a_r10_secv_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni) secv |=> secv);
  a_r10_secv_needs_assur: assert property (@(posedge clk_i) disable iff (!rst_ni) secv |-> ha_q);
  a_r12_state_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni) lfsr_q != '0);
endmodule

bind rand_word_regs rwg_checker #(.DATA_W(DATA_W)) u_rwg_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .go_q       (go_q),
  .ha_q       (ha_q),
  .intm_q     (intm_q),
  .asleep     (asleep),
  .uflow      (uflow),
  .clri_pulse (clri_pulse),
  .secv       (secv),
  .lrs        (lrs),
  .oru        (oru),
  .erri       (erri),
  .out_full   (out_full),
  .irq_o      (irq_o),
  .lfsr_q     (lfsr_q)
);

// File: tb/test_rand_word_regs.sv
module test_rand_word_regs;
  localparam logic [3:0] A_CTRL = 4'h0, A_STAT = 4'h4, A_ENT = 4'h8, A_OUT = 4'hC;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, doze_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  rand_word_regs i_rand_word_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .doze_i(doze_i), .irq_o(irq_o)
  );

  function automatic logic [31:0] st(bit secv, bit lrs, bit oru, bit err, bit slp, bit lvl);
    return 32'h0001_0000 | (32'(lvl) << 8) | (32'(slp) << 4) | (32'(err) << 3)
         | (32'(oru) << 2) | (32'(lrs) << 1) | 32'(secv);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    req_i = 0; we_i = 0;
  endtask

  task automatic bus_rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = a;
    #1 d = rdata_o;
    @(posedge clk_i); #1;
    req_i = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, w1, w2, prev;
    int since;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1;

    bus_rd(A_CTRL, d); check("R1 ctrl reset", d, 0);
    bus_rd(A_STAT, d); check("R1 stat reset", d, st(0,0,0,0,0,0));
    check("R1 irq reset", 32'(irq_o), 0);
    bus_wr(A_ENT, 32'hDEAD_BEEF);
    bus_rd(A_ENT, d); check("R2 entropy reads zero", d, 0);

    bus_rd(A_OUT, d); check("R6 empty read data", d, 0);
    check("R9 irq on error", 32'(irq_o), 1);
    bus_rd(A_STAT, d); check("R6 flags set", d, st(0,1,1,1,0,0));
    bus_rd(A_STAT, d); check("R7 status read clears", d, st(0,0,0,1,0,0));
    bus_wr(A_CTRL, 32'h4);
    check("R9 masked irq", 32'(irq_o), 0);
    bus_rd(A_CTRL, d); check("R2 mask readback", d, 32'h4);
    bus_wr(A_CTRL, 32'h8);
    bus_rd(A_STAT, d); check("R8 error cleared", d, st(0,0,0,0,0,0));
    bus_rd(A_CTRL, d); check("R2 clear bit reads 0", d, 0);

    bus_wr(A_CTRL, 32'h1);
    repeat (15) @(posedge clk_i);
    bus_rd(A_STAT, d); check("R4 empty at 15", d, st(0,0,0,0,0,0));
    bus_rd(A_STAT, d); check("R4 full at 16", d, st(0,0,0,0,0,1));
    bus_wr(A_CTRL, 32'h0);
    bus_rd(A_CTRL, d); check("R3 gen sticky", d, 32'h1);

    bus_rd(A_OUT, w1); check("R5 word nonzero", 32'(w1 != 0), 1);
    bus_rd(A_STAT, d); check("R5 emptied", d, st(0,0,0,0,0,0));
    bus_rd(A_OUT, d); check("R6 underflow data", d, 0);
    repeat (20) @(posedge clk_i);
    bus_rd(A_OUT, w2); check("R12 words differ", 32'(w2 != w1 && w2 != 0), 1);
    bus_rd(A_STAT, d); check("R5 valid read clears lrs only", d, st(0,0,1,1,0,0));
    bus_wr(A_CTRL, 32'h9);

    bus_wr(A_CTRL, 32'h11);
    bus_rd(A_STAT, d); check("R11 sleep bit", d, st(0,0,0,0,1,0));
    repeat (30) @(posedge clk_i);
    bus_rd(A_STAT, d); check("R11 no load asleep", d, st(0,0,0,0,1,0));
    doze_i = 1;
    bus_wr(A_CTRL, 32'h1);
    bus_rd(A_STAT, d); check("R11 doze sleep bit", d, st(0,0,0,0,1,0));
    repeat (30) @(posedge clk_i);
    bus_rd(A_STAT, d); check("R11 no load dozing", d, st(0,0,0,0,1,0));
    doze_i = 0;
    repeat (15) @(posedge clk_i);
    bus_rd(A_STAT, d); check("R11 wake empty at 15", d, st(0,0,0,0,0,0));
    bus_rd(A_STAT, d); check("R11 wake load at 16", d, st(0,0,0,0,0,1));

    bus_wr(A_CTRL, 32'h2);
    bus_rd(A_CTRL, d); check("R3 assur set", d, 32'h3);
    bus_rd(A_OUT, d);
    bus_rd(A_OUT, d); check("R10 underflow data", d, 0);
    bus_rd(A_STAT, d); check("R10 secv set", d, st(1,1,1,1,0,0));
    bus_wr(A_CTRL, 32'h8);
    bus_rd(A_STAT, d); check("R10 secv survives", d, st(1,0,0,0,0,0));
    bus_wr(A_CTRL, 32'h0);
    bus_rd(A_CTRL, d); check("R3 assur sticky", d, 32'h3);

    repeat (40) @(posedge clk_i);
    bus_rd(A_OUT, prev); check("R5 drain", 32'(prev != 0), 1);
    since = 0;
    for (int i = 0; i < 24; i++) begin
      int w;
      w = $urandom_range(0, 24);
      bus_wr(A_ENT, $urandom);
      repeat (w) @(posedge clk_i);
      since += 1 + w;
      bus_rd(A_OUT, d);
      if (since >= 16) begin
        check("R12 random valid word", 32'(d != 0 && d != prev), 1);
        prev = d;
        since = 0;
      end else begin
        check("R6 random underflow", d, 0);
        since += 1;
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule